// File: doc/BRIEF.md
# Per-Core Interrupt Doorbell and Mailbox Register Bank

This block is the register bank one processor core uses to receive inter-processor interrupts. Other agents post requests by writing a set port, which ORs bits into a 32-bit pending word. The owning core masks the pending word with a 32-bit enable word and acknowledges requests by writing a clear port. Eight 32-bit mailbox words sit alongside for passing small messages. The bank drives one level-sensitive interrupt line toward its core.

Access is through a single-beat register bus. A request is presented with `req_valid`, a write flag, an address and write data. The bank never stalls, so there is no ready signal and no back-pressure. Every accepted request produces a response exactly one cycle later on `rsp_valid`, carrying read data and an error flag. The response path cannot stall either, so the requester must take each response in the cycle it appears. Only the low eight address bits take part in decoding.

The interrupt line is set and cleared by conditions, not driven by a mask. A set write raises it when the updated pending word is nonzero and overlaps the enable word. A clear write lowers it only when it leaves the pending word empty while the enable word is nonzero. No other access moves the line.

Top module: `ipi_core_regs`

## Requirements
- R1: Only address bits [7:0] are decoded. Accesses that differ only in higher address bits reach the same register.
- R2: The pending-status word (offset 0x00) is read-only. A write to it leaves it unchanged and returns `rsp_err`=1.
- R3: A write to the enable word (offset 0x04) replaces all 32 bits, and a read of 0x04 returns the stored value.
- R4: A write to the set port (offset 0x08) ORs the data into status. If the new status is nonzero and (new status AND enable) is nonzero, `irq_o` becomes 1 one cycle later. Otherwise `irq_o` keeps its value.
- R5: A write to the clear port (offset 0x0C) ANDs status with the inverted data. If the new status is zero and enable is nonzero, `irq_o` becomes 0 one cycle later. Otherwise `irq_o` keeps its value.
- R6: Reads of the set and clear ports return zero without error.
- R7: Eight mailbox words occupy offsets 0x20–0x3F. The word index is (offset − 0x20) >> 2, so the two low offset bits are ignored inside this range. The words are readable and writable.
- R8: A read or write at any other offset returns zero data, changes nothing, and returns `rsp_err`=1 for that single response.
- R9: After synchronous reset, status, enable, every mailbox word and `irq_o` are zero.
- R10: Writing the enable word never changes `irq_o` by itself.
- R11: Each request with `req_valid`=1 produces exactly one `rsp_valid`=1 in the next cycle. Read data reflects the state before that request's own write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte address; bits [7:0] decoded |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| rsp_err | output | 1 | Illegal access: status write or undecoded offset |
| irq_o | output | 1 | Level interrupt toward the core |

## Verification
The status update and the interrupt decision happen on the same clock edge. The line must be judged against the status value that the set or clear write produces, not against the old value. The bench provokes this with set writes whose data alone meets the raise condition, and with clear writes that empty status exactly or leave one bit behind. It also covers the asymmetric case where a clear empties status while enable is zero, which must leave the line high. After every access, the bench compares `irq_o` and a read-back of status against an arithmetic model.

// File: rtl/ipi_regs_pkg.sv
package ipi_regs_pkg;

  localparam int unsigned DATA_W      = 32;
  localparam logic [7:0]  OFF_STATUS  = 8'h00;
  localparam logic [7:0]  OFF_ENABLE  = 8'h04;
  localparam logic [7:0]  OFF_SET     = 8'h08;
  localparam logic [7:0]  OFF_CLEAR   = 8'h0C;
  localparam int unsigned MBOX_BASE   = 32;

  typedef enum logic [1:0] {
    RSEL_ZERO   = 2'd0,
    RSEL_STATUS = 2'd1,
    RSEL_ENABLE = 2'd2,
    RSEL_MBOX   = 2'd3
  } rsel_e;

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_regs_pkg::*;
#(
  parameter int unsigned MBOX_WORDS = 8,
  localparam int unsigned IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic             valid,
  input  logic             we,
  input  logic [7:0]       off,
  output logic             en_we,
  output logic             set_we,
  output logic             clr_we,
  output logic             mb_we,
  output logic [IDX_W-1:0] mb_idx,
  output rsel_e            rsel,
  output logic             err
);

  localparam int unsigned MBOX_END = MBOX_BASE + 4 * MBOX_WORDS;

  logic [8:0] rel;
  logic       hit_stat, hit_en, hit_set, hit_clr, hit_mb, hit_any;

  assign rel      = {1'b0, off} - 9'(MBOX_BASE);
  assign hit_stat = (off == OFF_STATUS);
  assign hit_en   = (off == OFF_ENABLE);
  assign hit_set  = (off == OFF_SET);
  assign hit_clr  = (off == OFF_CLEAR);
  assign hit_mb   = ({1'b0, off} >= 9'(MBOX_BASE)) && ({1'b0, off} < 9'(MBOX_END));
  assign hit_any  = hit_stat | hit_en | hit_set | hit_clr | hit_mb;
  assign mb_idx   = rel[IDX_W+1:2];

  always_comb begin
    en_we  = valid && we && hit_en;
    set_we = valid && we && hit_set;
    clr_we = valid && we && hit_clr;
    mb_we  = valid && we && hit_mb;
    err    = valid && (!hit_any || (we && hit_stat));
    rsel   = RSEL_ZERO;
    if (valid && !we) begin
      if (hit_stat)    rsel = RSEL_STATUS;
      else if (hit_en) rsel = RSEL_ENABLE;
      else if (hit_mb) rsel = RSEL_MBOX;
    end
  end

  always_comb begin
    assert ($onehot0({en_we, set_we, clr_we, mb_we}))
      else $error("p_one_write_target_r8");
    assert (!(err && (en_we || set_we || clr_we || mb_we)))
      else $error("p_err_no_write_r8");
  end

endmodule

// File: rtl/ipi_status_irq.sv
module ipi_status_irq
  import ipi_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_we,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] enable,
  output logic              irq
);

  logic [DATA_W-1:0] set_next, clr_next;
  logic              raise, lower;

  assign set_next = status | wdata;
  assign clr_next = status & ~wdata;
  assign raise    = set_we && (set_next != '0) && ((set_next & enable) != '0);
  assign lower    = clr_we && (clr_next == '0) && (enable != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      if (en_we)       enable <= wdata;
      if (set_we)      status <= set_next;
      else if (clr_we) status <= clr_next;
      if (raise)       irq <= 1'b1;
      else if (lower)  irq <= 1'b0;
    end
  end

  p_irq_rise_on_set_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(set_we));
  p_irq_fall_on_clear_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> ($past(clr_we) && status == '0));
  p_enable_keeps_irq_r10: assert property (@(posedge clk) disable iff (rst)
    en_we |=> $stable(irq));
  p_status_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(status));
  p_set_raises_r4: assert property (@(posedge clk) disable iff (rst)
    (set_we && ((wdata & enable) != '0)) |=> irq);

endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_regs_pkg::*;
#(
  parameter int unsigned MBOX_WORDS = 8,
  localparam int unsigned IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] words [MBOX_WORDS];

  for (genvar g = 0; g < MBOX_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                 words[g] <= '0;
      else if (we && idx == IDX_W'(g))         words[g] <= wdata;
    end

    p_word_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !(we && idx == IDX_W'(g)) |=> $stable(words[g]));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < MBOX_WORDS; i++) begin
      if (idx == IDX_W'(i)) rdata = words[i];
    end
  end

endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
  import ipi_regs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned MBOX_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              irq_o
);

  localparam int unsigned IDX_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1;

  logic              en_we, set_we, clr_we, mb_we, dec_err;
  logic [IDX_W-1:0]  mb_idx;
  rsel_e             rsel;
  logic [DATA_W-1:0] status, enable, mb_rdata, rd_next;
  logic              unused_addr_hi;

  if (ADDR_W > 8) begin : g_hi
    assign unused_addr_hi = |req_addr[ADDR_W-1:8];
  end else begin : g_nohi
    assign unused_addr_hi = 1'b0;
  end

  ipi_addr_decode #(.MBOX_WORDS(MBOX_WORDS)) u_dec (
    .valid  (req_valid),
    .we     (req_we),
    .off    (req_addr[7:0]),
    .en_we  (en_we),
    .set_we (set_we),
    .clr_we (clr_we),
    .mb_we  (mb_we),
    .mb_idx (mb_idx),
    .rsel   (rsel),
    .err    (dec_err)
  );

  ipi_status_irq u_stat (
    .clk    (clk),
    .rst    (rst),
    .en_we  (en_we),
    .set_we (set_we),
    .clr_we (clr_we),
    .wdata  (req_wdata),
    .status (status),
    .enable (enable),
    .irq    (irq_o)
  );

  ipi_mailbox #(.MBOX_WORDS(MBOX_WORDS)) u_mbox (
    .clk   (clk),
    .rst   (rst),
    .we    (mb_we),
    .idx   (mb_idx),
    .wdata (req_wdata),
    .rdata (mb_rdata)
  );

  always_comb begin
    unique case (rsel)
      RSEL_STATUS: rd_next = status;
      RSEL_ENABLE: rd_next = enable;
      RSEL_MBOX:   rd_next = mb_rdata;
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= req_valid ? rd_next : '0;
      rsp_err   <= dec_err;
    end
  end

  p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_err_with_rsp_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid);
  p_err_data_zero_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0));

endmodule

// File: tb/ipi_core_regs_bench.sv
module ipi_core_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, irq_o;
  logic [31:0] rsp_rdata;

  int total = 0, bad = 0;
  logic [31:0] m_st = 0, m_en = 0;
  logic [31:0] m_mb [8];
  logic m_irq = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_core_regs u_ipi_core_regs (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic decoded(input logic [7:0] a);
    return a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h0C || (a >= 8'h20 && a < 8'h40);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return m_st;
    if (a == 8'h04) return m_en;
    if (a >= 8'h20 && a < 8'h40) return m_mb[(a - 8'h20) >> 2];
    return 32'h0;
  endfunction

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    chk("R11 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    logic [7:0] o;
    o = a[7:0];
    access(1'b1, a, d, rd, er);
    if (o == 8'h04) m_en = d;
    else if (o == 8'h08) begin
      m_st = m_st | d;
      if (m_st != 0 && (m_st & m_en) != 0) m_irq = 1'b1;
    end else if (o == 8'h0C) begin
      m_st = m_st & ~d;
      if (m_st == 0 && m_en != 0) m_irq = 1'b0;
    end else if (o >= 8'h20 && o < 8'h40) m_mb[(o - 8'h20) >> 2] = d;
    chk("R2 R8 write err flag", {31'b0, er}, {31'b0, (o == 8'h00) || !decoded(o)});
    chk("R4 R5 R10 irq", {31'b0, irq_o}, {31'b0, m_irq});
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a);
    logic [31:0] rd; logic er;
    access(1'b0, a, 32'h0, rd, er);
    chk(req, rd, exp_read(a[7:0]));
    chk("R8 read err flag", {31'b0, er}, {31'b0, !decoded(a[7:0])});
  endtask

  task automatic sweep_reads(input string req);
    for (int a = 0; a < 256; a++) rd_chk(req, AW'(a));
    @(negedge clk);
    chk("R11 idle no rsp", {31'b0, rsp_valid}, 32'd0);
    chk("R8 err pulse ends", {31'b0, rsp_err}, 32'd0);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 8; i++) m_mb[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 irq after reset", {31'b0, irq_o}, 32'd0);
    sweep_reads("R9 R6 R8 reset readback");

    for (int i = 0; i < 8; i++)
      wr(AW'(12'h300 | (8'h20 + 4*i + (i % 4))), 32'hA5000000 ^ (32'h01010101 * i));
    sweep_reads("R7 R1 mailbox readback");

    wr(12'h004, 32'hF0F0_0001);
    rd_chk("R3 enable readback", 12'hA04);
    wr(12'h000, 32'hFFFF_FFFF);
    rd_chk("R2 status unchanged", 12'h000);

    for (int a = 0; a < 256; a++)
      if (!decoded(8'(a))) wr(AW'(12'h100 | a), 32'hDEAD_BEEF);
    sweep_reads("R8 undecoded writes ignored");

    wr(12'h004, 32'h0);
    wr(12'h008, 32'h0000_0010);
    chk("R4 no raise without enable", {31'b0, irq_o}, 32'd0);
    wr(12'h004, 32'h0000_0010);
    chk("R10 enable write no raise", {31'b0, irq_o}, 32'd0);
    wr(12'h008, 32'h0);
    chk("R4 set raises", {31'b0, irq_o}, 32'd1);
    wr(12'h004, 32'h0);
    wr(12'h00C, 32'hFFFF_FFFF);
    chk("R5 stays high with enable zero", {31'b0, irq_o}, 32'd1);
    wr(12'h004, 32'h8000_0000);
    chk("R10 enable write no fall", {31'b0, irq_o}, 32'd1);
    wr(12'h00C, 32'h0);
    chk("R5 clear falls", {31'b0, irq_o}, 32'd0);
    wr(12'h008, 32'h8000_0001);
    wr(12'h00C, 32'h8000_0000);
    chk("R5 partial clear keeps irq", {31'b0, irq_o}, 32'd1);
    rd_chk("R5 status after partial clear", 12'h000);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] d;
      seed = nxt(seed);
      d = (32'd1 << seed[20:16]) | (seed[21] ? (32'd1 << seed[26:22]) : 32'd0);
      case (seed[29:28])
        2'd0: wr(12'h004, seed[31] ? d : 32'h0);
        2'd1: wr(12'h008, d);
        2'd2: wr(12'h00C, seed[30] ? 32'hFFFF_FFFF : d);
        default: wr(12'h00C, m_st);
      endcase
      rd_chk("R4 R5 status sweep", 12'h000);
      rd_chk("R6 set port reads zero", 12'h008);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule